// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit turns the addressing fields of an instruction into a 32-bit memory address. An address is the sum of up to three terms: a base register, an index register scaled by 1, 2 or 4, and a displacement that may be absent or 8, 16 or 32 bits wide. Each term can be left out on its own. Both registers are chosen from an eight-entry general register set, which the unit reads from a flat input bus.

The unit also serves the stack. A push request yields an address four below the current stack pointer, and that same value is the new stack pointer. A pop request yields the current stack pointer as the address, and the stack pointer plus four as its new value. The caller drives one request per cycle with `req_valid`. The results are registered and come out one cycle later with `res_valid`.

Top module: `eag_unit`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `res_valid` and `sp_wr` are 0 and `ea_out` and `sp_next` are zero.
- R2: `res_valid` is 1 in exactly the cycle after a cycle with `req_valid` high. After a cycle with `req_valid` low, `res_valid` and `sp_wr` are 0 and `ea_out` and `sp_next` keep their previous values.
- R3: For an address request (`op` = 2'b00, or the reserved code 2'b11), `ea_out` = base + scaled index + displacement modulo 2^32, with no overflow indication. The base term is register `base_sel` when `base_en` is 1 and zero otherwise. Register k occupies `gpr_flat[32k+31:32k]`.
- R4: The index term is register `index_sel` shifted left by `scale_code`: 2'b00 gives ×1, 2'b01 gives ×2, 2'b10 gives ×4, and the reserved code 2'b11 gives ×1. The term is zero when `index_en` is 0.
- R5: `disp_size` 2'b00 means no displacement. 2'b01 takes `disp[7:0]` sign-extended, 2'b10 takes `disp[15:0]` sign-extended, and 2'b11 takes all 32 bits. Bits above the selected width have no effect.
- R6: Register 4 is the stack pointer. When `index_sel` selects it, the index term is zero even with `index_en` set.
- R7: For a push (`op` = 2'b01), `ea_out` and `sp_next` both equal register 4 minus 4, modulo 2^32, and `sp_wr` is 1.
- R8: For a pop (`op` = 2'b10), `ea_out` equals register 4, `sp_next` equals register 4 plus 4 modulo 2^32, and `sp_wr` is 1.
- R9: For push and pop, the base, index, scale and displacement fields have no effect on any output.
- R10: For an address request, `sp_wr` is 0 and `sp_next` is zero.

Ports, in the order of the port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| op | input | 2 | 00 address, 01 push, 10 pop, 11 treated as address |
| base_en | input | 1 | Base term present |
| base_sel | input | 3 | Base register number |
| index_en | input | 1 | Index term present |
| index_sel | input | 3 | Index register number (4 means no index) |
| scale_code | input | 2 | Index shift amount |
| disp | input | 32 | Displacement field |
| disp_size | input | 2 | Displacement width code |
| gpr_flat | input | 256 | Eight 32-bit registers, register k at bits 32k+31..32k |
| res_valid | output | 1 | Results are valid |
| ea_out | output | 32 | Memory address |
| sp_wr | output | 1 | Stack pointer update is valid |
| sp_next | output | 32 | Updated stack pointer |

## Verification
Two functions can fall in the same cycle: a push or pop request can arrive while the addressing fields still hold a full base, scaled index and displacement pattern. The bench provokes this by driving live, non-zero addressing fields with every stack request, including stack pointer values that wrap at zero and at the top of the address space. It judges the result by requiring that `ea_out` and `sp_next` depend on register 4 alone. A separate sweep covers every combination of base, index, scale and displacement width over two displacement patterns. That sweep includes the stack pointer as the selected index, and it compares each address with a sum the bench computes itself.

// File: rtl/eag_pkg.sv
// Package: shared encodings for the effective address generator.
// Assumes: two-bit codes for the request kind and the displacement width.
package eag_pkg;

    typedef enum logic [1:0] {
        EAG_OP_ADDR = 2'b00,
        EAG_OP_PUSH = 2'b01,
        EAG_OP_POP  = 2'b10,
        EAG_OP_RSVD = 2'b11
    } eag_op_e;

    typedef enum logic [1:0] {
        EAG_DISP_NONE = 2'b00,
        EAG_DISP_B8   = 2'b01,
        EAG_DISP_B16  = 2'b10,
        EAG_DISP_B32  = 2'b11
    } eag_dsz_e;

endpackage

// File: rtl/eag_term_sel.sv
// Module: eag_term_sel
// Builds the three address terms: the base register, the scaled index
// register and the sign-extended displacement. Each term is zero when absent.
// Assumes: the register set arrives as a flat bus, entry k at slice k. The
// register numbered SP_IDX is never used as an index.
module eag_term_sel #(
    parameter int XLEN   = 32,
    parameter int NREG   = 8,
    parameter int SP_IDX = 4,
    localparam int SELW  = $clog2(NREG)
) (
    input  logic [NREG*XLEN-1:0] gpr_flat,
    input  logic                 base_en,
    input  logic [SELW-1:0]      base_sel,
    input  logic                 index_en,
    input  logic [SELW-1:0]      index_sel,
    input  logic [1:0]           scale_code,
    input  logic [XLEN-1:0]      disp,
    input  logic [1:0]           disp_size,
    output logic [XLEN-1:0]      base_term,
    output logic [XLEN-1:0]      index_term,
    output logic [XLEN-1:0]      disp_term
);
    import eag_pkg::*;

    logic [XLEN-1:0] gpr [NREG];
    logic [XLEN-1:0] index_raw;

    // Unpack the flat register bus into an array.
    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign gpr[g] = gpr_flat[g*XLEN +: XLEN];
    end

    // Base term: the selected register, or zero when absent.
    always_comb begin
        base_term = base_en ? gpr[base_sel] : '0;
    end

    // Index term: register read gated by presence and by the stack-pointer exclusion.
    always_comb begin
        index_raw = (index_en && (index_sel != SELW'(SP_IDX))) ? gpr[index_sel] : '0;
    end

    // Index scaling: shift by the scale code, with the reserved code meaning x1.
    always_comb begin
        case (scale_code)
            2'b01:   index_term = index_raw << 1;
            2'b10:   index_term = index_raw << 2;
            default: index_term = index_raw;
        endcase
    end

    // Displacement: pick the width and sign-extend it to the full word.
    always_comb begin
        case (eag_dsz_e'(disp_size))
            EAG_DISP_B8:   disp_term = {{(XLEN-8){disp[7]}}, disp[7:0]};
            EAG_DISP_B16:  disp_term = {{(XLEN-16){disp[15]}}, disp[15:0]};
            EAG_DISP_B32:  disp_term = disp;
            default:       disp_term = '0;
        endcase
    end

endmodule

// File: rtl/eag_sum3.sv
// Module: eag_sum3
// Three-operand adder that wraps modulo 2^XLEN and drops the carry.
// Assumes: all operands are already extended to XLEN bits.
module eag_sum3 #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] c,
    output logic [XLEN-1:0] sum
);
    // Plain truncating sum of the three terms.
    always_comb begin
        sum = a + b + c;
    end

endmodule

// File: rtl/eag_stack_step.sv
// Module: eag_stack_step
// Works out the access address and the new stack pointer for push and pop.
// A push decrements first and accesses the new value. A pop accesses the
// current value and then increments.
// Assumes: is_push selects push, otherwise pop. Arithmetic wraps.
module eag_stack_step #(
    parameter int XLEN = 32,
    parameter int STEP = 4
) (
    input  logic [XLEN-1:0] sp_cur,
    input  logic            is_push,
    output logic [XLEN-1:0] acc_addr,
    output logic [XLEN-1:0] sp_new
);
    localparam logic [XLEN-1:0] STEP_W = XLEN'(STEP);

    logic [XLEN-1:0] sp_dec;
    logic [XLEN-1:0] sp_inc;

    // Both candidate pointer values.
    always_comb begin
        sp_dec = sp_cur - STEP_W;
        sp_inc = sp_cur + STEP_W;
    end

    // Select pre-decrement for push, post-increment for pop.
    always_comb begin
        acc_addr = is_push ? sp_dec : sp_cur;
        sp_new   = is_push ? sp_dec : sp_inc;
    end

endmodule

// File: rtl/eag_unit.sv
// Module: eag_unit (top)
// Effective address generator. It accepts one request per cycle and gives
// registered results one cycle later. An address request sums base, scaled
// index and displacement. A push or pop request uses only the stack pointer.
// Assumes: the register set is supplied on gpr_flat every request cycle, and
// the stack pointer is register SP_IDX.
module eag_unit #(
    parameter int XLEN   = 32,
    parameter int NREG   = 8,
    parameter int SP_IDX = 4,
    parameter int STEP   = 4,
    localparam int SELW  = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           op,
    input  logic                 base_en,
    input  logic [SELW-1:0]      base_sel,
    input  logic                 index_en,
    input  logic [SELW-1:0]      index_sel,
    input  logic [1:0]           scale_code,
    input  logic [XLEN-1:0]      disp,
    input  logic [1:0]           disp_size,
    input  logic [NREG*XLEN-1:0] gpr_flat,
    output logic                 res_valid,
    output logic [XLEN-1:0]      ea_out,
    output logic                 sp_wr,
    output logic [XLEN-1:0]      sp_next
);
    import eag_pkg::*;

    logic [XLEN-1:0] base_term;
    logic [XLEN-1:0] index_term;
    logic [XLEN-1:0] disp_term;
    logic [XLEN-1:0] mem_sum;
    logic [XLEN-1:0] sp_cur;
    logic [XLEN-1:0] stk_addr;
    logic [XLEN-1:0] stk_sp;
    logic            is_stack;
    logic            is_push;
    logic [XLEN-1:0] ea_d;
    logic [XLEN-1:0] sp_d;

    eag_term_sel #(.XLEN(XLEN), .NREG(NREG), .SP_IDX(SP_IDX)) u_terms (
        .gpr_flat   (gpr_flat),
        .base_en    (base_en),
        .base_sel   (base_sel),
        .index_en   (index_en),
        .index_sel  (index_sel),
        .scale_code (scale_code),
        .disp       (disp),
        .disp_size  (disp_size),
        .base_term  (base_term),
        .index_term (index_term),
        .disp_term  (disp_term)
    );

    eag_sum3 #(.XLEN(XLEN)) u_sum (
        .a   (base_term),
        .b   (index_term),
        .c   (disp_term),
        .sum (mem_sum)
    );

    eag_stack_step #(.XLEN(XLEN), .STEP(STEP)) u_stack (
        .sp_cur   (sp_cur),
        .is_push  (is_push),
        .acc_addr (stk_addr),
        .sp_new   (stk_sp)
    );

    // Decode the request kind and fetch the stack pointer.
    always_comb begin
        is_push  = (eag_op_e'(op) == EAG_OP_PUSH);
        is_stack = is_push || (eag_op_e'(op) == EAG_OP_POP);
        sp_cur   = gpr_flat[SP_IDX*XLEN +: XLEN];
    end

    // Choose the next-state results by request kind.
    always_comb begin
        ea_d = is_stack ? stk_addr : mem_sum;
        sp_d = is_stack ? stk_sp   : '0;
    end

    // Output register: capture on an accepted request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            sp_wr     <= 1'b0;
            ea_out    <= '0;
            sp_next   <= '0;
        end else begin
            res_valid <= req_valid;
            sp_wr     <= req_valid && is_stack;
            if (req_valid) begin
                ea_out  <= ea_d;
                sp_next <= sp_d;
            end
        end
    end

endmodule

// File: rtl/eag_checker.sv
// Module: eag_checker
// Timing properties of eag_unit, attached to it by the bind below.
// Assumes: the same parameters as the unit, with the stack pointer at SP_IDX.
module eag_checker #(
    parameter int XLEN   = 32,
    parameter int NREG   = 8,
    parameter int SP_IDX = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [1:0]           op,
    input logic [NREG*XLEN-1:0] gpr_flat,
    input logic                 res_valid,
    input logic [XLEN-1:0]      ea_out,
    input logic                 sp_wr,
    input logic [XLEN-1:0]      sp_next
);
    // Result appears exactly one cycle after the request (R2).
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !sp_wr));

    // Push gives the pre-decremented pointer as both outputs (R7).
    assert_push_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == 2'b01) |=>
        (sp_wr && ea_out == sp_next &&
         ea_out == $past(gpr_flat[SP_IDX*XLEN +: XLEN]) - XLEN'(4)));

    // Pop accesses the current pointer and then increments it (R8).
    assert_pop_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == 2'b10) |=>
        (sp_wr && ea_out == $past(gpr_flat[SP_IDX*XLEN +: XLEN]) &&
         sp_next == ea_out + XLEN'(4)));

    // An address request leaves the stack pointer untouched (R10).
    assert_addr_no_sp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (op == 2'b00 || op == 2'b11)) |=> (!sp_wr && sp_next == '0));

    // A stack update is only ever reported together with a result (R2).
    assert_spwr_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr |-> res_valid);

endmodule

bind eag_unit eag_checker #(.XLEN(XLEN), .NREG(NREG), .SP_IDX(SP_IDX)) u_eag_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .op        (op),
    .gpr_flat  (gpr_flat),
    .res_valid (res_valid),
    .ea_out    (ea_out),
    .sp_wr     (sp_wr),
    .sp_next   (sp_next)
);

// File: tb/sim_eag_unit.sv
// Bench for eag_unit: a sweep over every addressing combination, stack
// requests with live addressing fields, then idle and reset checks.
module sim_eag_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [1:0]   op = 2'b00;
    logic         base_en = 1'b0;
    logic [2:0]   base_sel = 3'd0;
    logic         index_en = 1'b0;
    logic [2:0]   index_sel = 3'd0;
    logic [1:0]   scale_code = 2'b00;
    logic [31:0]  disp = 32'd0;
    logic [1:0]   disp_size = 2'b00;
    logic [255:0] gpr_flat = '0;
    logic         res_valid;
    logic [31:0]  ea_out;
    logic         sp_wr;
    logic [31:0]  sp_next;

    int n_checks = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    eag_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
        .base_en(base_en), .base_sel(base_sel), .index_en(index_en),
        .index_sel(index_sel), .scale_code(scale_code), .disp(disp),
        .disp_size(disp_size), .gpr_flat(gpr_flat), .res_valid(res_valid),
        .ea_out(ea_out), .sp_wr(sp_wr), .sp_next(sp_next)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] reg_of(input int k);
        return gpr_flat[k*32 +: 32];
    endfunction

    // Expected address from the requirements (R3, R4, R5, R6).
    function automatic logic [31:0] exp_addr();
        logic [31:0] b, x, d;
        logic [63:0] s;
        b = base_en ? reg_of(int'(base_sel)) : 32'd0;
        x = (index_en && index_sel != 3'd4) ? reg_of(int'(index_sel)) : 32'd0;
        x = x * ((scale_code == 2'd1) ? 32'd2 : (scale_code == 2'd2) ? 32'd4 : 32'd1);
        case (disp_size)
            2'd1: d = 32'(signed'(disp[7:0]));
            2'd2: d = 32'(signed'(disp[15:0]));
            2'd3: d = disp;
            default: d = 32'd0;
        endcase
        s = 64'(b) + 64'(x) + 64'(d);
        return s[31:0];
    endfunction

    // Present one request, then sample at the following falling edge.
    task automatic issue();
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] e_addr;
        for (int k = 0; k < 8; k++)
            gpr_flat[k*32 +: 32] = 32'h9E37_79B9 * (k + 1);
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        check("R1 res_valid", 32'(res_valid), 32'd0);
        check("R1 sp_wr", 32'(sp_wr), 32'd0);
        check("R1 ea_out", ea_out, 32'd0);
        check("R1 sp_next", sp_next, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 res_valid after release", 32'(res_valid), 32'd0);

        // R3 R4 R5 R6 R10: full sweep of address requests
        for (int pat = 0; pat < 2; pat++) begin
            for (int c = 0; c < 4096; c++) begin
                op = (c[0]) ? 2'b11 : 2'b00;
                base_en = c[1]; index_en = c[2];
                base_sel = c[5:3]; index_sel = c[8:6];
                scale_code = c[10:9];
                disp_size = {c[11], c[0]};
                disp = (pat == 0) ? 32'h1234_F6A9 : 32'h8765_4321;
                e_addr = exp_addr();
                issue();
                check("R2 res_valid after request", 32'(res_valid), 32'd1);
                check("R3 R4 R5 R6 address", ea_out, e_addr);
                check("R10 sp_wr on address request", 32'(sp_wr), 32'd0);
                check("R10 sp_next on address request", sp_next, 32'd0);
            end
        end

        // R7 R8 R9: stack requests with live addressing fields, incl. wrap
        for (int v = 0; v < 4; v++) begin
            logic [31:0] spv;
            spv = (v == 0) ? 32'd0 : (v == 1) ? 32'hFFFF_FFFC :
                  (v == 2) ? 32'h0000_1000 : 32'h8000_0002;
            gpr_flat[4*32 +: 32] = spv;
            for (int j = 0; j < 16; j++) begin
                base_en = 1'b1; index_en = 1'b1;
                base_sel = 3'(j); index_sel = 3'(j + 3);
                scale_code = 2'(j); disp_size = 2'(j >> 2);
                disp = 32'hDEAD_BEEF ^ 32'(j);
                op = 2'b01;
                issue();
                check("R7 R9 push address", ea_out, spv - 32'd4);
                check("R7 push new sp", sp_next, spv - 32'd4);
                check("R7 push sp_wr", 32'(sp_wr), 32'd1);
                op = 2'b10;
                issue();
                check("R8 R9 pop address", ea_out, spv);
                check("R8 pop new sp", sp_next, spv + 32'd4);
                check("R8 pop sp_wr", 32'(sp_wr), 32'd1);
            end
        end

        // R2: idle cycle after a push keeps data and drops the strobes
        op = 2'b01;
        issue();
        op = 2'b00; base_en = 1'b1; base_sel = 3'd1; disp_size = 2'b11; disp = 32'h5555_0000;
        @(posedge clk);
        @(negedge clk);
        check("R2 idle res_valid", 32'(res_valid), 32'd0);
        check("R2 idle sp_wr", 32'(sp_wr), 32'd0);
        check("R2 idle ea_out held", ea_out, 32'h8000_0002 - 32'd4);
        check("R2 idle sp_next held", sp_next, 32'h8000_0002 - 32'd4);

        // R1: a reset in mid-run clears the outputs again
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset res_valid", 32'(res_valid), 32'd0);
        check("R1 reset ea_out", ea_out, 32'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule